// File: doc/BRIEF.md
# PC Card Socket Strobe Sequencer

This block turns one decoded host request into a timed strobe sequence on one of the card sockets of a PC Card host adapter. It covers four kinds of card cycle: common memory, attribute memory, I/O, and DMA data transfer. Each kind has its own pattern on the active-low write-enable, output-enable, I/O-read, I/O-write and register-select lines. A DMA data cycle uses the I/O strobes while register-select stays high. During that cycle the two memory strobes are no longer data strobes: the one matching the transfer direction carries the terminal-count indication to the card.

A request is a socket number, an address space, a read/write flag, a width flag and a DMA acknowledge, plus a terminal-count bit that is meaningful only for DMA. The host side also supplies a two-bit DMA mode field and one DMA enable per socket. The block accepts the request only while idle. Each cycle then runs as one setup clock, a programmable number of active clocks and one hold clock. A done pulse marks the hold clock.

The DMA handshake is shared by all sockets, so a DMA acknowledge is routed to whichever socket alone has its DMA enable set. The socket number in the request is ignored for DMA. Address decoding, window mapping and the data path belong to other blocks.

Top module: `pccard_cycle_gen`

## Requirements
- R1: A common-memory request (`req_space` = 0, no DMA acknowledge) pulls `card_oe_n` (read) or `card_we_n` (write) low on the target socket during the active clocks. `card_iord_n`, `card_iowr_n` and `card_reg_n` stay high throughout.
- R2: An attribute-memory request (`req_space` = 1, no DMA acknowledge) strobes `card_oe_n`/`card_we_n` like R1. `card_iord_n` and `card_iowr_n` stay high, and `card_reg_n` is low on the target socket from the setup clock through the hold clock.
- R3: An I/O request (`req_space` = 2 or 3, no DMA acknowledge) pulls `card_iord_n` (read) or `card_iowr_n` (write) low during the active clocks. `card_we_n` and `card_oe_n` stay high, and `card_reg_n` is low for the whole cycle.
- R4: With a DMA acknowledge and a nonzero `dma_mode`, the cycle uses `card_iord_n`/`card_iowr_n` like R3 with `card_reg_n` high. If `req_tc` was high at acceptance, `card_oe_n` (read) or `card_we_n` (write) is also low during the active clocks; otherwise both stay high. The cycle goes to the one socket whose `dma_en` bit is set.
- R5: With `dma_mode` = 0, a DMA acknowledge yields a plain I/O cycle on `req_socket`. That cycle follows R3 exactly, and `req_tc` has no effect.
- R6: `wide_sel` equals the request's `req_wide` from the setup clock through the hold clock, and it is 0 while idle. The socket transfer width therefore follows the host cycle width, DMA included.
- R7: With a nonzero `dma_mode` and a `dma_en` that does not have exactly one bit set, a DMA acknowledge is accepted but produces no cycle: `busy` stays low and every card line stays high. `cfg_err` is high whenever more than one `dma_en` bit is set.
- R8: An accepted request gives one setup clock with the strobes high, then `active_width` active clocks (a value of 0 counts as 1), then one hold clock with the strobes high. `done` is high only on the hold clock, and the block is idle on the next clock.
- R9: `req_ready` is high only while idle. A request held valid during a cycle is not taken, and it starts no extra cycle.
- R10: Out of reset and while idle, every card line is high. At any time at most one socket has any of its lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_space | input | 2 | 0 common memory, 1 attribute memory, 2/3 I/O |
| req_dack | input | 1 | Request is a host DMA acknowledge |
| req_write | input | 1 | 1 = write to card, 0 = read from card |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| req_socket | input | SOCK_W | Target socket for non-DMA requests |
| req_tc | input | 1 | Terminal count for a DMA request |
| active_width | input | CNT_W | Active strobe length in clocks (0 treated as 1) |
| dma_mode | input | 2 | DMA mode field; zero disables DMA-type cycles |
| dma_en | input | NUM_SOCKETS | Per-socket DMA enable |
| card_we_n | output | NUM_SOCKETS | Write enable / write-direction terminal count |
| card_oe_n | output | NUM_SOCKETS | Output enable / read-direction terminal count |
| card_iord_n | output | NUM_SOCKETS | I/O read strobe |
| card_iowr_n | output | NUM_SOCKETS | I/O write strobe |
| card_reg_n | output | NUM_SOCKETS | Register-select line |
| wide_sel | output | 1 | 16-bit transfer select for the current cycle |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | High on the hold clock of a cycle |
| cfg_err | output | 1 | More than one socket is DMA-enabled |

## Verification
The embedded properties check, on every clock, the mutual exclusion of the two memory strobes and of the two I/O strobes, and that memory strobes stay high under a non-DMA I/O strobe. They also check that terminal count appears only with register-select high, that only one socket is ever driven, and that strobes fall only in the active phase. The phase order, the single-clock done pulse, the wide-select stability and the absence of a cycle after an ignored DMA acknowledge are checked on every clock as well. Only the bench scenarios can show that each address space maps to the right line on the right socket and that the active length matches the programmed width, including 0 and 15. The same holds for DMA routing to the enabled socket, the fall-back to I/O cycles with mode zero, and the hold-off of requests presented while busy.

// File: rtl/pccg_pkg.sv
package pccg_pkg;

   // cycle phase as seen by the strobe decoder
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_HOLD   = 2'd3
   } pccg_phase_e;

   // address space codes on req_space
   localparam logic [1:0] SPACE_COMMON = 2'd0;
   localparam logic [1:0] SPACE_ATTR   = 2'd1;

   // decoded command latched for the duration of a cycle
   typedef struct packed {
      logic mem_strobe;  // data moves on we/oe, otherwise on iord/iowr
      logic reg_low;     // register-select driven low for the cycle
      logic dma;         // DMA-type cycle, we/oe become terminal count
      logic tc;          // terminal count to present (DMA only)
      logic write;       // direction: 1 host to card
      logic wide;        // 16-bit transfer
   } pccg_cmd_t;

endpackage

// File: rtl/pccg_classify.sv
module pccg_classify
   import pccg_pkg::*;
#(
   parameter int NUM_SOCKETS = 2,
   parameter int SOCK_W      = 1
) (
   input  logic [1:0]             space,
   input  logic                   dack,
   input  logic                   write,
   input  logic                   wide,
   input  logic [SOCK_W-1:0]      socket,
   input  logic                   tc,
   input  logic [1:0]             dma_mode,
   input  logic [NUM_SOCKETS-1:0] dma_en,
   output pccg_cmd_t              cmd,
   output logic [SOCK_W-1:0]      target,
   output logic                   drop,
   output logic                   cfg_err
);

   localparam int CNT_BITS = $clog2(NUM_SOCKETS + 1);

   logic                dma_type;
   logic [CNT_BITS-1:0] en_count;
   logic [SOCK_W-1:0]   dma_target;

   assign dma_type = dack && (dma_mode != 2'b00);
   assign en_count = CNT_BITS'($countones(dma_en));

   // the single enabled socket takes the shared DMA handshake
   always_comb begin
      dma_target = '0;
      for (int i = 0; i < NUM_SOCKETS; i++) begin
         if (dma_en[i]) dma_target = SOCK_W'(i);
      end
   end

   always_comb begin
      cmd       = '0;
      cmd.write = write;
      cmd.wide  = wide;
      if (dma_type) begin
         cmd.dma = 1'b1;
         cmd.tc  = tc;
      end else if (dack) begin
         // DMA-type cycles disabled: plain I/O cycle
         cmd.reg_low = 1'b1;
      end else if (space == SPACE_COMMON) begin
         cmd.mem_strobe = 1'b1;
      end else if (space == SPACE_ATTR) begin
         cmd.mem_strobe = 1'b1;
         cmd.reg_low    = 1'b1;
      end else begin
         cmd.reg_low = 1'b1;
      end
   end

   assign target  = dma_type ? dma_target : socket;
   assign drop    = dma_type && (en_count != CNT_BITS'(1));
   assign cfg_err = en_count > CNT_BITS'(1);

endmodule

// File: rtl/pccg_seq.sv
module pccg_seq
   import pccg_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] width_in,
   output pccg_phase_e      phase,
   output logic             ready,
   output logic             done
);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         remain_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase    <= PH_SETUP;
                  remain_q <= (width_in == '0) ? CNT_W'(1) : width_in;
               end
            end
            PH_SETUP:  phase <= PH_ACTIVE;
            PH_ACTIVE: begin
               if (remain_q == CNT_W'(1)) phase <= PH_HOLD;
               else                       remain_q <= remain_q - CNT_W'(1);
            end
            PH_HOLD:   phase <= PH_IDLE;
            default:   phase <= PH_IDLE;
         endcase
      end
   end

   assign ready = (phase == PH_IDLE);
   assign done  = (phase == PH_HOLD);

   // R8: setup lasts exactly one clock
   a_r8_setup_one: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_SETUP |=> phase == PH_ACTIVE);

   // R8: hold lasts exactly one clock and returns to idle
   a_r8_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_HOLD |=> phase == PH_IDLE);

   // R9: a running cycle is never restarted
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACTIVE || phase == PH_HOLD) |=> phase != PH_SETUP);

endmodule

// File: rtl/pccg_strobe_map.sv
module pccg_strobe_map
   import pccg_pkg::*;
#(
   parameter int NUM_SOCKETS = 2,
   parameter int SOCK_W      = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  pccg_phase_e            phase,
   input  pccg_cmd_t              cmd,
   input  logic [SOCK_W-1:0]      sock,
   output logic [NUM_SOCKETS-1:0] we_n,
   output logic [NUM_SOCKETS-1:0] oe_n,
   output logic [NUM_SOCKETS-1:0] iord_n,
   output logic [NUM_SOCKETS-1:0] iowr_n,
   output logic [NUM_SOCKETS-1:0] reg_n
);

   logic in_cycle, in_active;
   logic drive_we, drive_oe, drive_rd, drive_wr;

   assign in_cycle  = (phase != PH_IDLE);
   assign in_active = (phase == PH_ACTIVE);

   // line intent before socket steering
   assign drive_we = (cmd.mem_strobe && cmd.write)
                   || (cmd.dma && cmd.tc && cmd.write);
   assign drive_oe = (cmd.mem_strobe && !cmd.write)
                   || (cmd.dma && cmd.tc && !cmd.write);
   assign drive_rd = !cmd.mem_strobe && !cmd.write;
   assign drive_wr = !cmd.mem_strobe && cmd.write;

   for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
      logic hit, hit_act;
      assign hit       = in_cycle && (sock == SOCK_W'(s));
      assign hit_act   = hit && in_active;
      assign we_n[s]   = !(hit_act && drive_we);
      assign oe_n[s]   = !(hit_act && drive_oe);
      assign iord_n[s] = !(hit_act && drive_rd);
      assign iowr_n[s] = !(hit_act && drive_wr);
      assign reg_n[s]  = !(hit && cmd.reg_low);
   end

   logic [NUM_SOCKETS-1:0] any_low;
   logic [NUM_SOCKETS-1:0] mem_low;
   logic [NUM_SOCKETS-1:0] io_low;
   assign any_low = ~(we_n & oe_n & iord_n & iowr_n & reg_n);
   assign mem_low = ~(we_n & oe_n);
   assign io_low  = ~(iord_n & iowr_n);

   // R10: only one socket is ever driven
   a_r10_one_socket: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(any_low));

   // R1: write and output enable never fall together
   a_r1_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
      ((~we_n) & (~oe_n)) == '0);

   // R3: I/O read and I/O write never fall together
   a_r3_io_excl: assert property (@(posedge clk) disable iff (!rst_n)
      ((~iord_n) & (~iowr_n)) == '0);

   // R3: a non-DMA I/O strobe leaves the memory strobes high
   a_r3_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (io_low & ~reg_n & mem_low) == '0);

   // R4: terminal count alongside an I/O strobe only with register-select high
   a_r4_tc_reg_high: assert property (@(posedge clk) disable iff (!rst_n)
      (io_low & mem_low & ~reg_n) == '0);

   // R8: strobes fall only in the active phase
   a_r8_strobe_active: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_low | io_low) != '0 |-> phase == PH_ACTIVE);

endmodule

// File: rtl/pccard_cycle_gen.sv
module pccard_cycle_gen
   import pccg_pkg::*;
#(
   parameter int NUM_SOCKETS = 2,
   parameter int CNT_W       = 4,
   parameter int SOCK_W      = (NUM_SOCKETS > 1) ? $clog2(NUM_SOCKETS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [1:0]             req_space,
   input  logic                   req_dack,
   input  logic                   req_write,
   input  logic                   req_wide,
   input  logic [SOCK_W-1:0]      req_socket,
   input  logic                   req_tc,
   input  logic [CNT_W-1:0]       active_width,
   input  logic [1:0]             dma_mode,
   input  logic [NUM_SOCKETS-1:0] dma_en,
   output logic [NUM_SOCKETS-1:0] card_we_n,
   output logic [NUM_SOCKETS-1:0] card_oe_n,
   output logic [NUM_SOCKETS-1:0] card_iord_n,
   output logic [NUM_SOCKETS-1:0] card_iowr_n,
   output logic [NUM_SOCKETS-1:0] card_reg_n,
   output logic                   wide_sel,
   output logic                   busy,
   output logic                   done,
   output logic                   cfg_err
);

   initial begin
      assert (NUM_SOCKETS >= 1 && NUM_SOCKETS <= 8)
         else $error("NUM_SOCKETS out of range");
      assert (CNT_W >= 1 && CNT_W <= 8)
         else $error("CNT_W out of range");
      assert (SOCK_W >= 1 && (1 << SOCK_W) >= NUM_SOCKETS)
         else $error("SOCK_W too narrow");
   end

   pccg_cmd_t         cmd_d, cmd_q;
   logic [SOCK_W-1:0] tgt_d, tgt_q;
   logic              drop;
   logic              start;
   logic              seq_ready;
   pccg_phase_e       phase;

   pccg_classify #(
      .NUM_SOCKETS (NUM_SOCKETS),
      .SOCK_W      (SOCK_W)
   ) u_classify (
      .space    (req_space),
      .dack     (req_dack),
      .write    (req_write),
      .wide     (req_wide),
      .socket   (req_socket),
      .tc       (req_tc),
      .dma_mode (dma_mode),
      .dma_en   (dma_en),
      .cmd      (cmd_d),
      .target   (tgt_d),
      .drop     (drop),
      .cfg_err  (cfg_err)
   );

   assign req_ready = seq_ready;
   assign start     = req_valid && seq_ready && !drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         tgt_q <= '0;
      end else if (start) begin
         cmd_q <= cmd_d;
         tgt_q <= tgt_d;
      end
   end

   pccg_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .width_in (active_width),
      .phase    (phase),
      .ready    (seq_ready),
      .done     (done)
   );

   pccg_strobe_map #(
      .NUM_SOCKETS (NUM_SOCKETS),
      .SOCK_W      (SOCK_W)
   ) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (phase),
      .cmd    (cmd_q),
      .sock   (tgt_q),
      .we_n   (card_we_n),
      .oe_n   (card_oe_n),
      .iord_n (card_iord_n),
      .iowr_n (card_iowr_n),
      .reg_n  (card_reg_n)
   );

   assign busy     = !seq_ready;
   assign wide_sel = busy && cmd_q.wide;

   // R6: width select holds still within a cycle
   a_r6_wide_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(wide_sel));

   // R7: an ignored DMA acknowledge starts nothing
   a_r7_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && drop) |=> !busy);

   // R8: done is a single clock and is followed by idle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   // R9: a cycle begins only from an accepted request
   a_r9_start_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> !busy);

endmodule

// File: tb/pccard_cycle_gen_bench.sv
module pccard_cycle_gen_bench;

   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_space = '0;
   logic          req_dack = 1'b0;
   logic          req_write = 1'b0;
   logic          req_wide = 1'b0;
   logic [0:0]    req_socket = '0;
   logic          req_tc = 1'b0;
   logic [3:0]    active_width = 4'd1;
   logic [1:0]    dma_mode = '0;
   logic [NS-1:0] dma_en = '0;
   logic [NS-1:0] card_we_n, card_oe_n, card_iord_n, card_iowr_n, card_reg_n;
   logic          wide_sel, busy, done, cfg_err;

   always #4 clk = ~clk;

   pccard_cycle_gen u_pccard_cycle_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_space    (req_space),
      .req_dack     (req_dack),
      .req_write    (req_write),
      .req_wide     (req_wide),
      .req_socket   (req_socket),
      .req_tc       (req_tc),
      .active_width (active_width),
      .dma_mode     (dma_mode),
      .dma_en       (dma_en),
      .card_we_n    (card_we_n),
      .card_oe_n    (card_oe_n),
      .card_iord_n  (card_iord_n),
      .card_iowr_n  (card_iowr_n),
      .card_reg_n   (card_reg_n),
      .wide_sel     (wide_sel),
      .busy         (busy),
      .done         (done),
      .cfg_err      (cfg_err)
   );

   typedef struct {
      int    sock;
      bit    mem;
      bit    reg_low;
      bit    dma;
      bit    tc;
      bit    wr;
      bit    wide;
      int    w;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // expected line levels {we,oe,iord,iowr,reg} for one socket; ph 0 setup/hold, 1 active
   function automatic logic [4:0] lines_for(exp_t e, int s, bit act);
      logic we, oe, rd, wr, rg;
      we = 1; oe = 1; rd = 1; wr = 1; rg = 1;
      if (s == e.sock) begin
         rg = !e.reg_low;
         if (act) begin
            if (e.mem) begin
               if (e.wr) we = 0; else oe = 0;
            end else begin
               if (e.wr) wr = 0; else rd = 0;
               if (e.dma && e.tc) begin
                  if (e.wr) we = 0; else oe = 0;
               end
            end
         end
      end
      return {we, oe, rd, wr, rg};
   endfunction

   function automatic logic [4:0] lines_act(int s);
      return {card_we_n[s], card_oe_n[s], card_iord_n[s], card_iowr_n[s], card_reg_n[s]};
   endfunction

   task automatic check_lines(exp_t e, bit act, string what);
      for (int s = 0; s < NS; s++) begin
         logic [4:0] x;
         x = lines_for(e, s, act);
         check(lines_act(s) === x, e.tag, $sformatf("%s socket %0d lines", what, s),
               int'(lines_act(s)), int'(x));
      end
   endtask

   // true when the request must be ignored (R7)
   function automatic bit dropped(bit dk);
      return dk && (dma_mode != 0) && ($countones(dma_en) != 1);
   endfunction

   task automatic issue(bit [1:0] sp, bit dk, bit wr, bit wd, int sk, bit tc, int w);
      exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_space = sp; req_dack = dk; req_write = wr; req_wide = wd;
      req_socket = sk[0:0]; req_tc = tc; active_width = w[3:0];
      e.wr = wr; e.wide = wd; e.w = (w == 0) ? 1 : w;
      e.dma = 0; e.tc = 0; e.mem = 0; e.reg_low = 0; e.sock = sk;
      if (dk && dma_mode != 0) begin
         e.dma = 1; e.tc = tc; e.tag = "R4";
         for (int i = 0; i < NS; i++) if (dma_en[i]) e.sock = i;
      end else if (dk) begin
         e.reg_low = 1; e.tag = "R5";
      end else if (sp == 0) begin
         e.mem = 1; e.tag = "R1";
      end else if (sp == 1) begin
         e.mem = 1; e.reg_low = 1; e.tag = "R2";
      end else begin
         e.reg_low = 1; e.tag = "R3";
      end
      if (!dropped(dk)) exp_q.push_back(e);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: pops one expected cycle per busy period
   int   mstate = 0;
   int   mcnt   = 0;
   exp_t cur;

   always @(negedge clk) begin
      if (rst_n) begin
         case (mstate)
            0: if (busy) begin
               if (exp_q.size() == 0) begin
                  check(0, "R9", "unexpected cycle start", 1, 0);
                  mstate = 3;
               end else begin
                  cur = exp_q.pop_front();
                  check_lines(cur, 0, "setup");
                  check(wide_sel === cur.wide, "R6", "wide_sel", int'(wide_sel), int'(cur.wide));
                  check(done === 1'b0, "R8", "done in setup", int'(done), 0);
                  mcnt = 0;
                  mstate = 1;
               end
            end
            1: begin
               check_lines(cur, 1, "active");
               mcnt++;
               if (mcnt == cur.w) mstate = 2;
            end
            2: begin
               check_lines(cur, 0, "hold");
               check(done === 1'b1, "R8", "done on hold", int'(done), 1);
               check(wide_sel === cur.wide, "R6", "wide_sel hold", int'(wide_sel), int'(cur.wide));
               mstate = 3;
            end
            default: begin
               check(!busy && req_ready, "R8", "idle after hold", int'(busy), 0);
               mstate = 0;
            end
         endcase
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy || exp_q.size() != 0 || mstate != 0) @(negedge clk);
   endtask

   task automatic check_quiet(string tag, int cycles);
      for (int i = 0; i < cycles; i++) begin
         check(!busy, tag, "busy after ignored request", int'(busy), 0);
         check((card_we_n & card_oe_n & card_iord_n & card_iowr_n & card_reg_n) === 2'b11,
               tag, "lines after ignored request",
               int'(card_we_n & card_oe_n & card_iord_n & card_iowr_n & card_reg_n), 3);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      check((card_we_n & card_oe_n & card_iord_n & card_iowr_n & card_reg_n) === 2'b11,
            "R10", "lines in reset", int'(card_we_n & card_oe_n & card_iord_n & card_iowr_n & card_reg_n), 3);
      check(req_ready === 1'b0 || req_ready === 1'b1, "R9", "ready known", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !busy && !done && !wide_sel, "R10", "idle after reset",
            int'({req_ready, busy, done, wide_sel}), 8);

      // R1 common memory
      issue(2'd0, 0, 0, 0, 0, 0, 3);
      issue(2'd0, 0, 1, 1, 1, 0, 2);
      // R2 attribute memory
      issue(2'd1, 0, 0, 0, 1, 0, 1);
      issue(2'd1, 0, 1, 1, 0, 0, 4);
      // R3 I/O
      issue(2'd2, 0, 0, 1, 0, 0, 2);
      issue(2'd3, 0, 1, 0, 1, 0, 5);
      wait_idle();

      // R4 DMA cycles routed to the enabled socket
      dma_mode = 2'd1; dma_en = 2'b01;
      issue(2'd0, 1, 0, 0, 1, 0, 2);
      issue(2'd0, 1, 1, 1, 1, 1, 3);
      wait_idle();
      dma_en = 2'b10; dma_mode = 2'd3;
      issue(2'd1, 1, 0, 1, 0, 1, 2);
      wait_idle();

      // R5 mode zero: DMA acknowledge as plain I/O, tc without effect
      dma_mode = 2'd0; dma_en = 2'b11;
      issue(2'd0, 1, 1, 0, 0, 1, 2);
      issue(2'd1, 1, 0, 1, 1, 1, 1);
      wait_idle();

      // R7 both sockets enabled: ignored, error flag raised
      dma_mode = 2'd2; dma_en = 2'b11;
      @(negedge clk);
      check(cfg_err === 1'b1, "R7", "cfg_err with two enables", int'(cfg_err), 1);
      issue(2'd0, 1, 0, 0, 0, 1, 3);
      check_quiet("R7", 3);
      // no socket enabled: ignored, no error flag
      dma_en = 2'b00;
      @(negedge clk);
      check(cfg_err === 1'b0, "R7", "cfg_err with no enable", int'(cfg_err), 0);
      issue(2'd0, 1, 1, 0, 1, 0, 3);
      check_quiet("R7", 3);
      // non-DMA traffic still runs with the bad setting
      dma_en = 2'b11;
      issue(2'd2, 0, 0, 0, 1, 0, 2);
      wait_idle();
      dma_en = 2'b00;

      // R8 width boundaries
      issue(2'd0, 0, 0, 0, 0, 0, 0);
      issue(2'd2, 0, 1, 1, 1, 0, 15);
      wait_idle();

      // R9 hold-off: a request presented while busy is not taken
      issue(2'd2, 0, 0, 0, 0, 0, 6);
      req_space = 2'd0; req_write = 1'b1; req_socket = 1'b1;
      req_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         check(req_ready === 1'b0, "R9", "ready while busy", int'(req_ready), 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
      check(!busy && exp_q.size() == 0, "R9", "no extra cycle", int'(busy), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule